// File: doc/BRIEF.md
# Control-Plane Erase and DMA Command Sequencer

This block sits behind an indexed host port made of a descriptor word and a data word. It reads only the writes whose descriptor selects the control access mode. From that traffic it picks out two kinds of command. The first is a single-write block erase. The second is a three-write DMA setup, which consists of a configuration word, a low address word and a high address word. Every other host write passes it by with no effect.

An erase turns into a one-cycle request to the flash side. The request carries the bank and the erase-block index. When the flash side acknowledges, the block raises a one-cycle success or failure event tagged with that bank. A DMA setup is collected step by step and bound to the bank and page of its first write. After the last write, one launch pulse goes to the DMA engine with direction, burst length, page count, bank, page and a 64-bit memory address. A busy flag then stays high until the engine reports done, and at that point a completion interrupt is raised if the configuration asked for one.

Top module: `ctrl_plane_seq`

## Requirements
- R1: After reset, `erase_req`, `dma_req`, both busy flags and all three interrupt pulses are low. The DMA sequence waits for a configuration word.
- R2: A host write is a control write only when `host_desc[31:26]` equals 6'd2, with bank in `host_desc[25:24]` and page in `host_desc[23:0]`. Any other write has no effect on erase, on DMA, or on the progress of an open DMA sequence.
- R3: A control write whose data is exactly 32'h0000_0001, made while no DMA sequence is open and no erase is busy, produces a one-cycle `erase_req` in the following cycle. It also sets `erase_bank` to the descriptor bank, `erase_block` to the page shifted right by PPB_LOG2 (default 6), and sets `erase_busy`.
- R4: An erase command made while `erase_busy` is high is dropped and leaves `erase_bank`/`erase_block` unchanged. An erase acknowledge that arrives while not busy raises no event.
- R5: An acknowledge while busy clears `erase_busy` and, in the next cycle, pulses `irq_erase_ok` (on `erase_ok_in`) or `irq_erase_fail` (on `erase_fail_in`) for one cycle, tagged by `irq_erase_bank`. If both acknowledges arrive together, only the failure is reported.
- R6: A configuration word is recognised by `data[15:9]` == 7'h10. Its fields are: page count `data[7:0]`, direction `data[8]` (1 = toward flash), burst length in bytes `data[23:16]`, and completion-interrupt request `data[24]`. At the configuration step, any other control data except the erase word is ignored.
- R7: Configuration, low address and high address written in that order with an identical descriptor give one `dma_req` pulse in the cycle after the third write. With it come `dma_addr` = {high, low} and the configuration fields, bank and page.
- R8: A control write at the second or third step whose bank or page differs from the first write abandons the sequence. That write is discarded, no launch occurs, and the next accepted word must again be a configuration word.
- R9: `dma_busy` rises with `dma_req` and holds until `dma_done_in`. Configuration words arriving while it is high are ignored, and the launch parameters stay unchanged.
- R10: `dma_done_in` while busy clears `dma_busy` and, in the next cycle, pulses `irq_dma_done` for one cycle only if the interrupt-request bit was set.
- R11: While a DMA sequence is open, a matching control write with data 32'h1 is taken as an address word and starts no erase.
- R12: The erase and DMA paths are independent. Events of the two paths may fall in the same cycle and each is reported in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the descriptor/data pair |
| host_desc | input | 32 | Descriptor: access mode, bank, page |
| host_data | input | 32 | Data word of the write |
| erase_req | output | 1 | One-cycle erase request to the flash side |
| erase_bank | output | 2 | Bank of the erase in progress |
| erase_block | output | 24 | Erase-block index (page >> PPB_LOG2) |
| erase_busy | output | 1 | Erase outstanding |
| erase_ok_in | input | 1 | Flash side reports erase success |
| erase_fail_in | input | 1 | Flash side reports erase failure |
| irq_erase_ok | output | 1 | One-cycle erase success event |
| irq_erase_fail | output | 1 | One-cycle erase failure event |
| irq_erase_bank | output | 2 | Bank tag of the erase event |
| dma_req | output | 1 | One-cycle launch to the DMA engine |
| dma_to_flash | output | 1 | Direction, 1 = memory to flash |
| dma_burst | output | 8 | Burst length in bytes |
| dma_pages | output | 8 | Page count |
| dma_bank | output | 2 | Bank of the transfer |
| dma_page | output | 24 | Start page of the transfer |
| dma_addr | output | 64 | Memory address |
| dma_busy | output | 1 | Transfer outstanding |
| dma_done_in | input | 1 | DMA engine reports completion |
| irq_dma_done | output | 1 | One-cycle completion interrupt |

## Verification
Two pairs of events can fall in the same cycle. The final address write of a DMA setup can coincide with an erase acknowledge. A DMA completion can coincide with an erase failure. The bench provokes both by driving the high address write together with `erase_ok_in`, and `dma_done_in` together with `erase_fail_in`, on the same edge. It then requires that both the launch and the erase event appear in the next cycle, and that both completion pulses appear there, each with its own correct tag and busy flag cleared.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int BANK_W   = 2;
  localparam int PAGE_W   = 24;
  localparam int WORD_W   = 32;
  localparam int CNT_W    = 8;
  localparam int MODE_LSB = PAGE_W + BANK_W;
  localparam int MODE_W   = WORD_W - MODE_LSB;

  localparam logic [MODE_W-1:0] CTRL_MODE  = MODE_W'(2);
  localparam logic [WORD_W-1:0] ERASE_WORD = WORD_W'(1);
  localparam logic [6:0]        CFG_TAG    = 7'h10;

  typedef enum logic [1:0] {
    STEP_CFG = 2'd0,
    STEP_LO  = 2'd1,
    STEP_HI  = 2'd2
  } step_e;

  typedef struct packed {
    logic             irq_en;
    logic [CNT_W-1:0] burst;
    logic             to_flash;
    logic [CNT_W-1:0] pages;
  } xfer_cfg_t;

  function automatic logic is_cfg_word(input logic [WORD_W-1:0] w);
    return w[15:9] == CFG_TAG;
  endfunction

  function automatic xfer_cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
    xfer_cfg_t r;
    r.irq_en   = w[24];
    r.burst    = w[23:16];
    r.to_flash = w[8];
    r.pages    = w[7:0];
    return r;
  endfunction

  function automatic logic [PAGE_W-1:0] block_of(input logic [PAGE_W-1:0] page,
                                                 input int unsigned sh);
    return page >> sh;
  endfunction
endpackage

// File: rtl/cps_decode.sv
module cps_decode
  import cps_pkg::*;
(
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_desc,
  input  logic [WORD_W-1:0] host_data,
  output logic              ctrl_wr,
  output logic [BANK_W-1:0] bank,
  output logic [PAGE_W-1:0] page,
  output logic              erase_hit,
  output logic              cfg_hit,
  output xfer_cfg_t         cfg
);
  assign ctrl_wr   = host_wr && (host_desc[WORD_W-1:MODE_LSB] == CTRL_MODE);
  assign bank      = host_desc[MODE_LSB-1:PAGE_W];
  assign page      = host_desc[PAGE_W-1:0];
  assign erase_hit = ctrl_wr && (host_data == ERASE_WORD);
  assign cfg_hit   = ctrl_wr && is_cfg_word(host_data);
  assign cfg       = unpack_cfg(host_data);
endmodule

// File: rtl/cps_dma_seq.sv
module cps_dma_seq
  import cps_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_wr,
  input  logic                cfg_hit,
  input  logic [BANK_W-1:0]   bank,
  input  logic [PAGE_W-1:0]   page,
  input  xfer_cfg_t           cfg,
  input  logic [WORD_W-1:0]   data,
  input  logic                dma_done_in,
  output logic                dma_req,
  output logic                dma_busy,
  output logic                irq_dma_done,
  output xfer_cfg_t           cfg_q,
  output logic [BANK_W-1:0]   tag_bank,
  output logic [PAGE_W-1:0]   tag_page,
  output logic [2*WORD_W-1:0] dma_addr,
  output step_e               step,
  output logic                seq_idle,
  output logic                abort_evt,
  output logic                launch_evt
);
  logic [WORD_W-1:0] lo_q;
  logic same_tag, start_evt, done_evt;

  assign same_tag   = (bank == tag_bank) && (page == tag_page);
  assign seq_idle   = (step == STEP_CFG);
  assign start_evt  = seq_idle && cfg_hit && !dma_busy;
  assign abort_evt  = ctrl_wr && !seq_idle && !same_tag;
  assign launch_evt = ctrl_wr && (step == STEP_HI) && same_tag;
  assign done_evt   = dma_done_in && dma_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step         <= STEP_CFG;
      cfg_q        <= '0;
      tag_bank     <= '0;
      tag_page     <= '0;
      lo_q         <= '0;
      dma_addr     <= '0;
      dma_req      <= 1'b0;
      dma_busy     <= 1'b0;
      irq_dma_done <= 1'b0;
    end else begin
      dma_req      <= launch_evt;
      irq_dma_done <= done_evt && cfg_q.irq_en;
      if (launch_evt)    dma_busy <= 1'b1;
      else if (done_evt) dma_busy <= 1'b0;

      if (abort_evt) begin
        step <= STEP_CFG;
      end else begin
        unique case (step)
          STEP_CFG: if (start_evt) begin
            cfg_q    <= cfg;
            tag_bank <= bank;
            tag_page <= page;
            step     <= STEP_LO;
          end
          STEP_LO: if (ctrl_wr) begin
            lo_q <= data;
            step <= STEP_HI;
          end
          STEP_HI: if (ctrl_wr) begin
            dma_addr <= {data, lo_q};
            step     <= STEP_CFG;
          end
          default: step <= STEP_CFG;
        endcase
      end
    end
  end
endmodule

// File: rtl/cps_erase.sv
module cps_erase
  import cps_pkg::*;
#(
  parameter int unsigned PPB_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_go,
  input  logic [BANK_W-1:0] bank,
  input  logic [PAGE_W-1:0] page,
  input  logic              ok_in,
  input  logic              fail_in,
  output logic              erase_req,
  output logic [BANK_W-1:0] erase_bank,
  output logic [PAGE_W-1:0] erase_block,
  output logic              erase_busy,
  output logic              irq_ok,
  output logic              irq_fail,
  output logic [BANK_W-1:0] irq_bank
);
  logic issue, finish;

  assign issue    = erase_go && !erase_busy;
  assign finish   = erase_busy && (ok_in || fail_in);
  assign irq_bank = erase_bank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      erase_req   <= 1'b0;
      erase_bank  <= '0;
      erase_block <= '0;
      erase_busy  <= 1'b0;
      irq_ok      <= 1'b0;
      irq_fail    <= 1'b0;
    end else begin
      erase_req <= issue;
      irq_fail  <= finish && fail_in;
      irq_ok    <= finish && !fail_in;
      if (issue) begin
        erase_bank  <= bank;
        erase_block <= block_of(page, PPB_LOG2);
        erase_busy  <= 1'b1;
      end else if (finish) begin
        erase_busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctrl_plane_seq.sv
module ctrl_plane_seq
  import cps_pkg::*;
#(
  parameter int unsigned PPB_LOG2 = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic [WORD_W-1:0]   host_desc,
  input  logic [WORD_W-1:0]   host_data,
  output logic                erase_req,
  output logic [BANK_W-1:0]   erase_bank,
  output logic [PAGE_W-1:0]   erase_block,
  output logic                erase_busy,
  input  logic                erase_ok_in,
  input  logic                erase_fail_in,
  output logic                irq_erase_ok,
  output logic                irq_erase_fail,
  output logic [BANK_W-1:0]   irq_erase_bank,
  output logic                dma_req,
  output logic                dma_to_flash,
  output logic [CNT_W-1:0]    dma_burst,
  output logic [CNT_W-1:0]    dma_pages,
  output logic [BANK_W-1:0]   dma_bank,
  output logic [PAGE_W-1:0]   dma_page,
  output logic [2*WORD_W-1:0] dma_addr,
  output logic                dma_busy,
  input  logic                dma_done_in,
  output logic                irq_dma_done
);
  logic              ctrl_wr, erase_hit, cfg_hit;
  logic [BANK_W-1:0] dec_bank;
  logic [PAGE_W-1:0] dec_page;
  xfer_cfg_t         dec_cfg, held_cfg;
  step_e             seq_step;
  logic              seq_idle, seq_abort, seq_launch;

  cps_decode u_dec (
    .host_wr   (host_wr),
    .host_desc (host_desc),
    .host_data (host_data),
    .ctrl_wr   (ctrl_wr),
    .bank      (dec_bank),
    .page      (dec_page),
    .erase_hit (erase_hit),
    .cfg_hit   (cfg_hit),
    .cfg       (dec_cfg)
  );

  cps_dma_seq u_dma (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr      (ctrl_wr),
    .cfg_hit      (cfg_hit),
    .bank         (dec_bank),
    .page         (dec_page),
    .cfg          (dec_cfg),
    .data         (host_data),
    .dma_done_in  (dma_done_in),
    .dma_req      (dma_req),
    .dma_busy     (dma_busy),
    .irq_dma_done (irq_dma_done),
    .cfg_q        (held_cfg),
    .tag_bank     (dma_bank),
    .tag_page     (dma_page),
    .dma_addr     (dma_addr),
    .step         (seq_step),
    .seq_idle     (seq_idle),
    .abort_evt    (seq_abort),
    .launch_evt   (seq_launch)
  );

  assign dma_to_flash = held_cfg.to_flash;
  assign dma_burst    = held_cfg.burst;
  assign dma_pages    = held_cfg.pages;

  cps_erase #(.PPB_LOG2(PPB_LOG2)) u_ers (
    .clk         (clk),
    .rst_n       (rst_n),
    .erase_go    (erase_hit && seq_idle),
    .bank        (dec_bank),
    .page        (dec_page),
    .ok_in       (erase_ok_in),
    .fail_in     (erase_fail_in),
    .erase_req   (erase_req),
    .erase_bank  (erase_bank),
    .erase_block (erase_block),
    .erase_busy  (erase_busy),
    .irq_ok      (irq_erase_ok),
    .irq_fail    (irq_erase_fail),
    .irq_bank    (irq_erase_bank)
  );
endmodule

// File: rtl/cps_checker.sv
module cps_checker
  import cps_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                host_wr,
  input logic [WORD_W-1:0]   host_desc,
  input logic                erase_req,
  input logic                erase_busy,
  input logic                erase_ok_in,
  input logic                erase_fail_in,
  input logic                irq_erase_ok,
  input logic                irq_erase_fail,
  input logic                dma_req,
  input logic                dma_busy,
  input logic                dma_done_in,
  input logic [2*WORD_W-1:0] dma_addr,
  input logic                irq_dma_done,
  input logic [1:0]          seq_step,
  input logic                seq_abort,
  input logic                seq_launch
);
  AST_NONCTRL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_desc[WORD_W-1:MODE_LSB] != CTRL_MODE) |=> (!dma_req && !erase_req)); // R2
  AST_ERASE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req); // R3
  AST_ERASE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> erase_busy); // R3
  AST_ERASE_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && !erase_ok_in && !erase_fail_in) |=> !erase_req); // R4
  AST_ERASE_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_erase_ok && irq_erase_fail)); // R5
  AST_ERASE_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && (erase_ok_in || erase_fail_in)) |=> (!erase_busy && (irq_erase_ok || irq_erase_fail))); // R5
  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    seq_step != 2'd3); // R7
  AST_LAUNCH_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req); // R7
  AST_LAUNCH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_launch |=> dma_req); // R7
  AST_ABORT_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> (!dma_req && seq_step == 2'd0)); // R8
  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> dma_busy); // R9
  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_busy && !dma_done_in) |=> !dma_req); // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    dma_busy |=> (!dma_busy || $stable(dma_addr))); // R9
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dma_done |-> !dma_busy); // R10
endmodule

bind ctrl_plane_seq cps_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_wr        (host_wr),
  .host_desc      (host_desc),
  .erase_req      (erase_req),
  .erase_busy     (erase_busy),
  .erase_ok_in    (erase_ok_in),
  .erase_fail_in  (erase_fail_in),
  .irq_erase_ok   (irq_erase_ok),
  .irq_erase_fail (irq_erase_fail),
  .dma_req        (dma_req),
  .dma_busy       (dma_busy),
  .dma_done_in    (dma_done_in),
  .dma_addr       (dma_addr),
  .irq_dma_done   (irq_dma_done),
  .seq_step       (seq_step),
  .seq_abort      (seq_abort),
  .seq_launch     (seq_launch)
);

// File: tb/sim_ctrl_plane_seq.sv
module sim_ctrl_plane_seq;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, host_wr, erase_ok_in, erase_fail_in, dma_done_in;
  logic [31:0] host_desc, host_data;
  logic        erase_req, erase_busy, irq_erase_ok, irq_erase_fail;
  logic [1:0]  erase_bank, irq_erase_bank, dma_bank;
  logic [23:0] erase_block, dma_page;
  logic        dma_req, dma_to_flash, dma_busy, irq_dma_done;
  logic [7:0]  dma_burst, dma_pages;
  logic [63:0] dma_addr;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  ctrl_plane_seq u0 (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dsc(logic [5:0] m, logic [1:0] b, logic [23:0] p);
    return {m, b, p};
  endfunction

  function automatic logic [31:0] cfgw(bit irq, logic [7:0] burst, bit dir, logic [7:0] pages);
    return {7'd0, irq, burst, 7'h10, dir, pages};
  endfunction

  task automatic wr(logic [31:0] d, logic [31:0] v);
    host_wr = 1'b1; host_desc = d; host_data = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic seq3(logic [1:0] b, logic [23:0] p, logic [31:0] c,
                      logic [31:0] lo, logic [31:0] hi);
    wr(dsc(6'd2, b, p), c);
    wr(dsc(6'd2, b, p), lo);
    wr(dsc(6'd2, b, p), hi);
  endtask

  task automatic dma_finish(bit exp_irq);
    dma_done_in = 1'b1;
    @(negedge clk);
    dma_done_in = 1'b0;
    check("R10 irq_dma_done", 64'(irq_dma_done), 64'(exp_irq));
    check("R10 busy cleared", 64'(dma_busy), 64'd0);
    @(negedge clk);
    check("R10 irq one cycle", 64'(irq_dma_done), 64'd0);
  endtask

  task automatic erase_ack(bit ok, bit fail);
    erase_ok_in = ok; erase_fail_in = fail;
    @(negedge clk);
    erase_ok_in = 1'b0; erase_fail_in = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_desc = '0; host_data = '0;
    erase_ok_in = 1'b0; erase_fail_in = 1'b0; dma_done_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 dma_req in reset", 64'(dma_req), 64'd0);
    check("R1 erase_req in reset", 64'(erase_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy flags", {62'd0, dma_busy, erase_busy}, 64'd0);
    check("R1 irq pulses", {61'd0, irq_dma_done, irq_erase_ok, irq_erase_fail}, 64'd0);

    // R7 / R10 sweep over bank, direction, interrupt request
    for (int b = 0; b < 4; b++)
      for (int d = 0; d < 2; d++)
        for (int q = 0; q < 2; q++) begin
          logic [23:0] p;
          logic [31:0] lo, hi;
          logic [7:0]  n;
          p  = 24'(b * 4099 + d * 17 + q * 3 + 5);
          lo = 32'hA000_0000 + 32'(b * 4096 + d * 16 + q);
          hi = 32'h0000_0100 * 32'(b + 1) + 32'(d);
          n  = 8'(b * 3 + d + 1);
          seq3(2'(b), p, cfgw(q[0], 8'd64, d[0], n), lo, hi);
          check("R7 dma_req", 64'(dma_req), 64'd1);
          check("R7 dma_addr", dma_addr, {hi, lo});
          check("R7 fields", {dma_to_flash, dma_pages, dma_burst}, {d[0], n, 8'd64});
          check("R7 tag", {dma_bank, dma_page}, {2'(b), p});
          check("R9 busy set", 64'(dma_busy), 64'd1);
          @(negedge clk);
          check("R7 req one cycle", 64'(dma_req), 64'd0);
          dma_finish(q[0]);
        end

    // R2: non-control writes inside an open sequence have no effect
    wr(dsc(6'd2, 2'd1, 24'd20), cfgw(1'b0, 8'd64, 1'b1, 8'd2));
    for (int m = 0; m < 4; m++) begin
      logic [5:0] md;
      md = (m == 3) ? 6'h22 : ((m == 2) ? 6'd3 : 6'(m));
      wr(dsc(md, 2'd1, 24'd20), 32'hDEAD_0000 + 32'(m));
      check("R2 no dma_req", 64'(dma_req), 64'd0);
      wr(dsc(md, 2'd1, 24'd20), 32'd1);
      check("R2 no erase_req", 64'(erase_req), 64'd0);
    end
    wr(dsc(6'd2, 2'd1, 24'd20), 32'h1111_0000);
    wr(dsc(6'd2, 2'd1, 24'd20), 32'h0000_0022);
    check("R2 launch intact", 64'(dma_req), 64'd1);
    check("R2 addr from control words", dma_addr, 64'h0000_0022_1111_0000);
    @(negedge clk);
    dma_finish(1'b0);

    // R9: configuration while busy is ignored, parameters held
    seq3(2'd1, 24'd100, cfgw(1'b1, 8'd64, 1'b0, 8'd1), 32'h5555_0000, 32'h0000_0077);
    check("R9 first launch", 64'(dma_req), 64'd1);
    wr(dsc(6'd2, 2'd2, 24'd7), cfgw(1'b0, 8'd32, 1'b1, 8'd9));
    check("R9 cfg while busy", 64'(dma_req), 64'd0);
    wr(dsc(6'd2, 2'd2, 24'd7), 32'h1234_0000);
    wr(dsc(6'd2, 2'd2, 24'd7), 32'h0000_0055);
    check("R9 no second launch", 64'(dma_req), 64'd0);
    check("R9 addr held", dma_addr, 64'h0000_0077_5555_0000);
    check("R9 params held", {dma_bank, dma_pages, dma_to_flash}, {2'd1, 8'd1, 1'b0});
    dma_finish(1'b1);
    seq3(2'd2, 24'd7, cfgw(1'b0, 8'd32, 1'b1, 8'd9), 32'h1234_0000, 32'h0000_0055);
    check("R9 launch after done", dma_addr, 64'h0000_0055_1234_0000);
    @(negedge clk);
    dma_finish(1'b0);

    // R8: descriptor mismatch abandons the sequence
    wr(dsc(6'd2, 2'd3, 24'd50), cfgw(1'b0, 8'd64, 1'b0, 8'd4));
    wr(dsc(6'd2, 2'd2, 24'd50), 32'h0BAD_0000);
    check("R8 bank mismatch", 64'(dma_req), 64'd0);
    wr(dsc(6'd2, 2'd3, 24'd50), 32'h0000_0033);
    check("R8 stray hi ignored", 64'(dma_req), 64'd0);
    wr(dsc(6'd2, 2'd0, 24'd9), cfgw(1'b0, 8'd64, 1'b0, 8'd4));
    wr(dsc(6'd2, 2'd0, 24'd9), 32'h0BAD_0100);
    wr(dsc(6'd2, 2'd0, 24'd10), 32'h0000_0044);
    check("R8 page mismatch", 64'(dma_req), 64'd0);
    seq3(2'd0, 24'd9, cfgw(1'b0, 8'd64, 1'b0, 8'd4), 32'h0600_0000, 32'h0000_0066);
    check("R8 restart launch", 64'(dma_req), 64'd1);
    check("R8 fresh address", dma_addr, 64'h0000_0066_0600_0000);
    @(negedge clk);
    dma_finish(1'b0);

    // R6: configuration tag must match exactly
    wr(dsc(6'd2, 2'd1, 24'd3), cfgw(1'b0, 8'd64, 1'b0, 8'd1) & ~32'h2000);
    wr(dsc(6'd2, 2'd1, 24'd3), 32'h0000_0800);
    wr(dsc(6'd2, 2'd1, 24'd3), 32'h0000_0008);
    check("R6 untagged ignored", 64'(dma_req), 64'd0);
    wr(dsc(6'd2, 2'd1, 24'd3), cfgw(1'b0, 8'd64, 1'b0, 8'd1) | 32'h0200);
    wr(dsc(6'd2, 2'd1, 24'd3), 32'h0000_0800);
    wr(dsc(6'd2, 2'd1, 24'd3), 32'h0000_0008);
    check("R6 wrong tag ignored", 64'(dma_req), 64'd0);
    seq3(2'd1, 24'd3, cfgw(1'b0, 8'h80, 1'b1, 8'hFF), 32'h0000_0800, 32'h0000_0008);
    check("R6 field decode", {dma_req, dma_to_flash, dma_burst, dma_pages}, {1'b1, 1'b1, 8'h80, 8'hFF});
    @(negedge clk);
    dma_finish(1'b0);

    // R11: erase word inside an open sequence is an address
    wr(dsc(6'd2, 2'd1, 24'd8), cfgw(1'b0, 8'd64, 1'b0, 8'd1));
    wr(dsc(6'd2, 2'd1, 24'd8), 32'd1);
    check("R11 no erase", {62'd0, erase_req, erase_busy}, 64'd0);
    wr(dsc(6'd2, 2'd1, 24'd8), 32'h0000_0009);
    check("R11 addr low is one", dma_addr, 64'h0000_0009_0000_0001);
    @(negedge clk);
    dma_finish(1'b0);

    // R3 / R5 erase sweep
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 4; k++) begin
        logic [23:0] p;
        bit fl;
        p  = (k == 0) ? 24'd63 : (k == 1) ? 24'd64 : (k == 2) ? 24'hFFFFFF : 24'(b * 1000 + 77);
        fl = ((b + k) % 2) == 1;
        wr(dsc(6'd2, 2'(b), p), 32'd1);
        check("R3 erase_req", 64'(erase_req), 64'd1);
        check("R3 bank/block", {erase_bank, erase_block}, {2'(b), 24'(p / 64)});
        check("R3 busy", 64'(erase_busy), 64'd1);
        @(negedge clk);
        check("R3 one cycle", 64'(erase_req), 64'd0);
        erase_ack(!fl, fl);
        check("R5 event", {irq_erase_ok, irq_erase_fail}, {!fl, fl});
        check("R5 tag", 64'(irq_erase_bank), 64'(b));
        check("R5 busy cleared", 64'(erase_busy), 64'd0);
        @(negedge clk);
        check("R5 one cycle", {irq_erase_ok, irq_erase_fail}, 2'b00);
      end

    // R4: erase while busy dropped; stray acknowledge ignored
    wr(dsc(6'd2, 2'd2, 24'd640), 32'd1);
    wr(dsc(6'd2, 2'd3, 24'd128), 32'd1);
    check("R4 no reissue", 64'(erase_req), 64'd0);
    check("R4 target held", {erase_bank, erase_block}, {2'd2, 24'd10});
    erase_ack(1'b1, 1'b0);
    check("R4 first ok", 64'(irq_erase_ok), 64'd1);
    @(negedge clk);
    erase_ack(1'b1, 1'b0);
    check("R4 stray ack", {irq_erase_ok, irq_erase_fail}, 2'b00);

    // R5: both acknowledges together
    wr(dsc(6'd2, 2'd1, 24'd0), 32'd1);
    erase_ack(1'b1, 1'b1);
    check("R5 fail wins", {irq_erase_ok, irq_erase_fail}, 2'b01);

    // R12: coincident events of both paths
    @(negedge clk);
    wr(dsc(6'd2, 2'd0, 24'd1000), 32'd1);
    wr(dsc(6'd2, 2'd2, 24'd5), cfgw(1'b1, 8'd64, 1'b1, 8'd2));
    wr(dsc(6'd2, 2'd2, 24'd5), 32'h0CC0_0000);
    host_wr = 1'b1; host_desc = dsc(6'd2, 2'd2, 24'd5); host_data = 32'h0000_00DD;
    erase_ok_in = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; erase_ok_in = 1'b0;
    check("R12 launch with erase ok", {dma_req, irq_erase_ok}, 2'b11);
    check("R12 tags", {dma_addr, 6'd0, irq_erase_bank}, {64'h0000_00DD_0CC0_0000, 6'd0, 2'd0});
    wr(dsc(6'd2, 2'd3, 24'd0), 32'd1);
    check("R12 erase while dma busy", {erase_req, dma_busy}, 2'b11);
    dma_done_in = 1'b1; erase_fail_in = 1'b1;
    @(negedge clk);
    dma_done_in = 1'b0; erase_fail_in = 1'b0;
    check("R12 both completions", {irq_dma_done, irq_erase_fail, irq_erase_ok}, 3'b110);
    check("R12 bank and busy", {irq_erase_bank, dma_busy, erase_busy}, {2'd3, 2'b00});

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule